// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Sequencer

This block sits between a synchronous host and an external static RAM that has no clock. The host presents a request together with a read/write flag, an address, write data and a per-lane byte mask. While the sequencer is idle it accepts the request, reports busy, and plays out a memory bus cycle. Each phase of that cycle is a whole number of clocks, and each count is worked out at elaboration from the clock period and the memory's minimum timing figures. Reads end with the captured data and a one-cycle valid pulse.

A write starts with a setup clock in which the new address, the chip enables and the lane strobes are applied while write enable stays high. Write enable is then pulled low for the write pulse, and the data bus is driven only during that pulse. A recovery phase follows, with write enable high again, and it stretches the cycle to the minimum write cycle time. A read holds chip enable and output enable low for the longest of the address, read-cycle and output-enable access times, and captures the bus on its last clock. When a write is accepted right after a read, turnaround clocks are inserted first, so that the memory's output drivers have released the bus before the controller drives it.

Top module: `sram_async_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, busy and rd_valid are 0, mem_ce_n is 1, mem_ce2 is 0, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, and every mem_bls_n bit is 1.
- R2: A request is accepted only on a clock edge at which busy is 0. Requests presented while busy is 1 start no operation and do not change the address, the data or the lane outputs.
- R3: A write drives mem_we_n high for 1 setup cycle, then low for WP_CYC = max(ceil(T_WP/T_CLK), ceil(T_DW/T_CLK)) cycles, then high for REC_CYC cycles. REC_CYC is WC_CYC-WP_CYC-1 when that is positive and 1 otherwise, with WC_CYC = ceil(T_WC/T_CLK).
- R4: mem_addr takes the request address on the edge that accepts the request. It never changes while mem_we_n is 0.
- R5: mem_dq_oe is 1 exactly in the cycles where mem_we_n is 0, and mem_dq_out then carries the request's write data. mem_oe_n stays 1 for the whole of every write.
- R6: A read holds mem_oe_n low and mem_we_n high for RD_CYC = max(ceil(T_RC/T_CLK), ceil(T_AA/T_CLK), ceil(T_OE/T_CLK)) cycles, starting in the cycle after acceptance.
- R7: Read data is sampled from mem_dq_in on the last read cycle. rd_valid is then 1 for exactly the next cycle, and rd_data is returned in that cycle. A lane whose mask bit is 0 reads as zero. Mask bit 0 covers data bits 7:0 and bit 1 covers bits 15:8.
- R8: During an operation mem_bls_n[i] is the inverse of the request mask bit i. In idle, all mem_bls_n bits are 1.
- R9: If the most recently accepted operation was a read, a newly accepted write first spends TURN_CYC = ceil(T_OHZ/T_CLK) cycles with mem_we_n and mem_oe_n high and mem_dq_oe 0, and only then starts its setup cycle.
- R10: busy is 1 from the cycle after acceptance through the last cycle of the operation, and 0 otherwise. The chip enables (mem_ce_n low, mem_ce2 high) are active in exactly the cycles where busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe, sampled while idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | LANES*LANE_W | Write data |
| req_be | input | LANES | Per-lane enable mask |
| busy | output | 1 | Operation in progress; requests ignored |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | LANES*LANE_W | Read data, disabled lanes zero |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_bls_n | output | LANES | Active-low lane strobes |
| mem_dq_out | output | LANES*LANE_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the bus drivers |
| mem_dq_in | input | LANES*LANE_W | Data returned by the memory |

## Verification
The assertions assume a synchronous reset and a nonzero phase count loaded into the timer. They also assume that mem_dq_in matters only during a read's access phase. No assertion depends on the host holding req or its payload steady: the payload is registered on the accepting edge and ignored after that. The stimulus therefore presents requests in idle cycles, right after a read's valid cycle, and on every cycle of a busy operation. It changes address, mask and data between requests, so that any late capture or early drive would show up at the memory pins. The bench's memory model answers only when the chip enables and the output enable are active, and it drives a marker value on disabled lanes so that the read-mask zeroing can be observed.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TURN,
      ST_SETUP,
      ST_WPULSE,
      ST_WRECOV,
      ST_READ
   } seq_st_t;

   // clocks needed to cover a minimum time, rounded up
   function automatic int unsigned clocks_for(input int unsigned t_ps,
                                              input int unsigned clk_ps);
      return (t_ps + clk_ps - 1) / clk_ps;
   endfunction

   function automatic int unsigned max_of(input int unsigned a,
                                          input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last = (cnt_q == CNT_W'(1));

   // R3: every timed phase lasts at least one cycle
   p_load_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
      load |-> (load_val != '0));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_seq_pkg::*;
#(
   parameter int unsigned CNT_W    = 4,
   parameter int unsigned WP_CYC   = 4,
   parameter int unsigned REC_CYC  = 2,
   parameter int unsigned RD_CYC   = 7,
   parameter int unsigned TURN_CYC = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic req,
   input  logic req_we,
   output logic accept,
   output logic capture,
   output logic op_done,
   output logic busy,
   output logic ce_act,
   output logic we_n,
   output logic oe_n,
   output logic dq_oe
);

   seq_st_t          state_q, state_nx;
   logic             last_rd_q;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_last;

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .last     (tmr_last)
   );

   always_comb begin
      state_nx = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      capture  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req) begin
               if (!req_we) begin
                  state_nx = ST_READ;
                  tmr_load = 1'b1;
                  tmr_val  = CNT_W'(RD_CYC);
               end else if (last_rd_q) begin
                  state_nx = ST_TURN;
                  tmr_load = 1'b1;
                  tmr_val  = CNT_W'(TURN_CYC);
               end else begin
                  state_nx = ST_SETUP;
               end
            end
         end
         ST_TURN: begin
            if (tmr_last) state_nx = ST_SETUP;
         end
         ST_SETUP: begin
            state_nx = ST_WPULSE;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(WP_CYC);
         end
         ST_WPULSE: begin
            if (tmr_last) begin
               state_nx = ST_WRECOV;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(REC_CYC);
            end
         end
         ST_WRECOV: begin
            if (tmr_last) state_nx = ST_IDLE;
         end
         ST_READ: begin
            if (tmr_last) begin
               state_nx = ST_IDLE;
               capture  = 1'b1;
            end
         end
         default: state_nx = ST_IDLE;
      endcase
   end

   assign accept  = (state_q == ST_IDLE) && req;
   assign op_done = (state_q != ST_IDLE) && (state_nx == ST_IDLE);
   assign busy    = (state_q != ST_IDLE);

   // strobes come straight from flops so the memory never sees decode glitches
   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         last_rd_q <= 1'b0;
         ce_act    <= 1'b0;
         we_n      <= 1'b1;
         oe_n      <= 1'b1;
         dq_oe     <= 1'b0;
      end else begin
         state_q <= state_nx;
         if (accept) last_rd_q <= !req_we;
         ce_act <= (state_nx != ST_IDLE);
         we_n   <= (state_nx != ST_WPULSE);
         oe_n   <= (state_nx != ST_READ);
         dq_oe  <= (state_nx == ST_WPULSE);
      end
   end

   // checker counters: length of the write pulse, idle time of output enable
   logic [CNT_W:0]   wlow_cnt;
   logic [CNT_W-1:0] hiz_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         wlow_cnt <= '0;
         hiz_cnt  <= CNT_W'(TURN_CYC);
      end else begin
         wlow_cnt <= we_n ? '0 : wlow_cnt + 1'b1;
         if (!oe_n) hiz_cnt <= '0;
         else if (hiz_cnt != CNT_W'(TURN_CYC)) hiz_cnt <= hiz_cnt + 1'b1;
      end
   end

   p_no_contention_r5: assert property (@(posedge clk) disable iff (rst)
      !(!we_n && !oe_n));

   p_drive_with_we_r5: assert property (@(posedge clk) disable iff (rst)
      dq_oe |-> !we_n);

   p_pulse_len_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(we_n) |-> (wlow_cnt == (CNT_W+1)'(WP_CYC)));

   p_hiz_turn_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(dq_oe) |-> (hiz_cnt == CNT_W'(TURN_CYC)));

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (!ce_act && we_n && oe_n && !dq_oe));

endmodule

// File: rtl/sram_lane_path.sv
module sram_lane_path #(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned LANE_W = 8,
   parameter int unsigned LANES  = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    accept,
   input  logic                    op_done,
   input  logic                    capture,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [LANES*LANE_W-1:0] req_wdata,
   input  logic [LANES-1:0]        req_be,
   input  logic [LANES*LANE_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic [LANES*LANE_W-1:0] mem_dq_out,
   output logic [LANES-1:0]        mem_bls_n,
   output logic                    rd_valid,
   output logic [LANES*LANE_W-1:0] rd_data
);

   logic [LANES-1:0] be_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         mem_addr   <= '0;
         mem_dq_out <= '0;
         be_q       <= '0;
         mem_bls_n  <= '1;
         rd_valid   <= 1'b0;
      end else begin
         if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
            be_q       <= req_be;
            mem_bls_n  <= ~req_be;
         end else if (op_done) begin
            mem_bls_n  <= '1;
         end
         rd_valid <= capture;
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk) begin
         if (rst) begin
            rd_data[i*LANE_W +: LANE_W] <= '0;
         end else if (capture) begin
            rd_data[i*LANE_W +: LANE_W] <= be_q[i] ? mem_dq_in[i*LANE_W +: LANE_W]
                                                   : '0;
         end
      end
   end

   p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_async_seq.sv
module sram_async_seq
   import sram_seq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 17,
   parameter int unsigned LANE_W    = 8,
   parameter int unsigned LANES     = 2,
   parameter int unsigned CLK_PS    = 8000,
   parameter int unsigned T_WC_PS   = 55000,
   parameter int unsigned T_WP_PS   = 30000,
   parameter int unsigned T_DW_PS   = 25000,
   parameter int unsigned T_RC_PS   = 55000,
   parameter int unsigned T_AA_PS   = 55000,
   parameter int unsigned T_OE_PS   = 30000,
   parameter int unsigned T_OHZ_PS  = 25000
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    req,
   input  logic                    req_we,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [LANES*LANE_W-1:0] req_wdata,
   input  logic [LANES-1:0]        req_be,
   output logic                    busy,
   output logic                    rd_valid,
   output logic [LANES*LANE_W-1:0] rd_data,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic                    mem_ce_n,
   output logic                    mem_ce2,
   output logic                    mem_we_n,
   output logic                    mem_oe_n,
   output logic [LANES-1:0]        mem_bls_n,
   output logic [LANES*LANE_W-1:0] mem_dq_out,
   output logic                    mem_dq_oe,
   input  logic [LANES*LANE_W-1:0] mem_dq_in
);

   localparam int unsigned WP_CYC   = max_of(clocks_for(T_WP_PS, CLK_PS),
                                             clocks_for(T_DW_PS, CLK_PS));
   localparam int unsigned WC_CYC   = clocks_for(T_WC_PS, CLK_PS);
   localparam int unsigned REC_CYC  = (WC_CYC > WP_CYC + 1) ? WC_CYC - WP_CYC - 1 : 1;
   localparam int unsigned RD_CYC   = max_of(max_of(clocks_for(T_RC_PS, CLK_PS),
                                                    clocks_for(T_AA_PS, CLK_PS)),
                                             clocks_for(T_OE_PS, CLK_PS));
   localparam int unsigned TURN_CYC = clocks_for(T_OHZ_PS, CLK_PS);
   localparam int unsigned MAX_CYC  = max_of(max_of(WP_CYC, REC_CYC),
                                             max_of(RD_CYC, TURN_CYC));
   localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

   if (CLK_PS == 0 || LANES == 0 || LANE_W == 0 || ADDR_W == 0) begin : g_bad_shape
      $error("sram_async_seq: clock period and bus shape must be nonzero");
   end
   if (WP_CYC < 1 || RD_CYC < 1 || TURN_CYC < 1 || WC_CYC < 1) begin : g_bad_phase
      $error("sram_async_seq: every timing figure must give at least one clock");
   end

   logic accept, capture, op_done, ce_act;

   sram_seq_fsm #(
      .CNT_W    (CNT_W),
      .WP_CYC   (WP_CYC),
      .REC_CYC  (REC_CYC),
      .RD_CYC   (RD_CYC),
      .TURN_CYC (TURN_CYC)
   ) u_fsm (
      .clk     (clk),
      .rst     (rst),
      .req     (req),
      .req_we  (req_we),
      .accept  (accept),
      .capture (capture),
      .op_done (op_done),
      .busy    (busy),
      .ce_act  (ce_act),
      .we_n    (mem_we_n),
      .oe_n    (mem_oe_n),
      .dq_oe   (mem_dq_oe)
   );

   sram_lane_path #(
      .ADDR_W (ADDR_W),
      .LANE_W (LANE_W),
      .LANES  (LANES)
   ) u_lanes (
      .clk        (clk),
      .rst        (rst),
      .accept     (accept),
      .op_done    (op_done),
      .capture    (capture),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .req_be     (req_be),
      .mem_dq_in  (mem_dq_in),
      .mem_addr   (mem_addr),
      .mem_dq_out (mem_dq_out),
      .mem_bls_n  (mem_bls_n),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data)
   );

   assign mem_ce_n = !ce_act;
   assign mem_ce2  = ce_act;

   p_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |-> $stable(mem_addr));

   p_accept_idle_r2: assert property (@(posedge clk) disable iff (rst)
      busy |=> $stable(mem_addr) || !$past(busy));

endmodule

// File: tb/sram_async_seq_tb.sv
`timescale 1ns/1ps
module sram_async_seq_tb_top;

   localparam int CLK_PS = 8000;
   localparam int WP_N   = ((30000 + CLK_PS - 1) / CLK_PS > (25000 + CLK_PS - 1) / CLK_PS)
                           ? (30000 + CLK_PS - 1) / CLK_PS : (25000 + CLK_PS - 1) / CLK_PS;
   localparam int WC_N   = (55000 + CLK_PS - 1) / CLK_PS;
   localparam int REC_N  = (WC_N - WP_N - 1 > 0) ? WC_N - WP_N - 1 : 1;
   localparam int RD_N   = (55000 + CLK_PS - 1) / CLK_PS;
   localparam int TURN_N = (25000 + CLK_PS - 1) / CLK_PS;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req = 1'b0;
   logic        req_we = 1'b0;
   logic [16:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        busy, rd_valid, mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [15:0] rd_data, mem_dq_out, mem_dq_in;
   logic [16:0] mem_addr;
   logic [1:0]  mem_bls_n;

   always #4 clk = ~clk;

   sram_async_seq dut_i (
      .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_be(req_be), .busy(busy), .rd_valid(rd_valid),
      .rd_data(rd_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_bls_n(mem_bls_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // memory model: 16 words, disabled lanes return a marker byte
   logic [15:0] sram_arr [16];
   logic [15:0] gold [16];
   wire sel = !mem_ce_n && mem_ce2;
   assign mem_dq_in = (sel && !mem_oe_n && mem_we_n) ?
      {mem_bls_n[1] ? 8'hEE : sram_arr[mem_addr[3:0]][15:8],
       mem_bls_n[0] ? 8'hEE : sram_arr[mem_addr[3:0]][7:0]} : 16'h0000;

   always @(posedge clk) begin
      if (sel && !mem_we_n && mem_dq_oe) begin
         if (!mem_bls_n[0]) sram_arr[mem_addr[3:0]][7:0]  <= mem_dq_out[7:0];
         if (!mem_bls_n[1]) sram_arr[mem_addr[3:0]][15:8] <= mem_dq_out[15:8];
      end
   end

   typedef struct {
      logic        busy, ce, we_n, oe_n, dq_oe, rdv;
      logic [16:0] addr;
      logic [1:0]  bls_n;
      logic [15:0] wd, rd;
   } exp_t;

   exp_t q[$];
   exp_t cur;
   bit   last_rd = 0;
   bit   in_reset = 1;
   bit   done = 0;
   int   n_tests = 0;
   int   n_fail = 0;

   function automatic exp_t idle_e();
      exp_t e;
      e.busy = 0; e.ce = 0; e.we_n = 1; e.oe_n = 1; e.dq_oe = 0; e.rdv = 0;
      e.addr = '0; e.bls_n = 2'b11; e.wd = '0; e.rd = '0;
      return e;
   endfunction

   function automatic exp_t op_e(input logic [16:0] a, input logic [1:0] be);
      exp_t e;
      e = idle_e();
      e.busy = 1; e.ce = 1; e.addr = a; e.bls_n = ~be;
      return e;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h at %0t",
                  in_reset ? "R1" : tag, what, act, exp, $time);
      end
   endtask

   task automatic cmp_cycle();
      cur = (q.size() > 0) ? q.pop_front() : idle_e();
      chk(busy === cur.busy, "R10", "busy", 32'(busy), 32'(cur.busy));
      chk(mem_ce_n === !cur.ce && mem_ce2 === cur.ce, "R10", "chip enables",
          {mem_ce_n, mem_ce2}, {!cur.ce, cur.ce});
      chk(mem_we_n === cur.we_n, "R3", "we_n", 32'(mem_we_n), 32'(cur.we_n));
      chk(mem_oe_n === cur.oe_n, "R6", "oe_n", 32'(mem_oe_n), 32'(cur.oe_n));
      chk(mem_dq_oe === cur.dq_oe, "R5", "dq_oe", 32'(mem_dq_oe), 32'(cur.dq_oe));
      chk(mem_bls_n === cur.bls_n, "R8", "lane strobes", 32'(mem_bls_n), 32'(cur.bls_n));
      chk(rd_valid === cur.rdv, "R7", "rd_valid", 32'(rd_valid), 32'(cur.rdv));
      if (cur.dq_oe) chk(mem_dq_out === cur.wd, "R5", "write data", 32'(mem_dq_out), 32'(cur.wd));
      if (cur.ce) chk(mem_addr === cur.addr, "R4", "address", 32'(mem_addr), 32'(cur.addr));
      if (cur.rdv) chk(rd_data === cur.rd, "R7", "read data", 32'(rd_data), 32'(cur.rd));
   endtask

   task automatic push_wr(input logic [16:0] a, input logic [15:0] d, input logic [1:0] be);
      exp_t e;
      e = op_e(a, be);
      if (last_rd) for (int i = 0; i < TURN_N; i++) q.push_back(e);   // R9 turnaround
      q.push_back(e);                                               // setup
      e.we_n = 0; e.dq_oe = 1; e.wd = d;
      for (int i = 0; i < WP_N; i++) q.push_back(e);
      e.we_n = 1; e.dq_oe = 0;
      for (int i = 0; i < REC_N; i++) q.push_back(e);
      if (be[0]) gold[a[3:0]][7:0]  = d[7:0];
      if (be[1]) gold[a[3:0]][15:8] = d[15:8];
      last_rd = 0;
   endtask

   task automatic push_rd(input logic [16:0] a, input logic [1:0] be);
      exp_t e;
      e = op_e(a, be);
      e.oe_n = 0;
      for (int i = 0; i < RD_N; i++) q.push_back(e);
      e = idle_e();
      e.rdv = 1;
      e.rd = {be[1] ? gold[a[3:0]][15:8] : 8'h00, be[0] ? gold[a[3:0]][7:0] : 8'h00};
      q.push_back(e);
      last_rd = 1;
   endtask

   task automatic step(input bit r, input bit we, input logic [16:0] a,
                       input logic [15:0] d, input logic [1:0] be);
      @(negedge clk);
      cmp_cycle();
      req = r; req_we = we; req_addr = a; req_wdata = d; req_be = be;
      if (r && !in_reset && !cur.busy && q.size() == 0) begin
         if (we) push_wr(a, d, be);
         else    push_rd(a, be);
      end
   endtask

   task automatic do_op(input bit we, input logic [16:0] a, input logic [15:0] d,
                        input logic [1:0] be, input bit noisy);
      step(1, we, a, d, be);
      while (q.size() > 0) begin
         if (noisy) step(1, !we, a ^ 17'h5, ~d, ~be);   // R2: ignored while busy
         else       step(0, 0, '0, '0, '0);
      end
   endtask

   initial begin
      for (int i = 0; i < 16; i++) begin
         sram_arr[i] = 16'hA000 + 16'(i * 16'h0101);
         gold[i]     = 16'hA000 + 16'(i * 16'h0101);
      end
      // R1: reset state
      repeat (3) step(0, 0, '0, '0, '0);
      rst = 0;
      in_reset = 0;
      step(0, 0, '0, '0, '0);
      // R3 R5 R4: full-word write, then read back (R6 R7)
      do_op(1, 17'h00001, 16'h1234, 2'b11, 0);
      step(0, 0, '0, '0, '0);
      do_op(0, 17'h00001, '0, 2'b11, 0);
      // R9: write right after read gets turnaround; lower lane only (R8)
      do_op(1, 17'h10002, 16'hBEEF, 2'b01, 0);
      step(0, 0, '0, '0, '0);
      do_op(0, 17'h10002, '0, 2'b11, 0);
      // R7: masked read, lower lane returns zero
      do_op(0, 17'h00003, '0, 2'b10, 0);
      // R2: requests during a write are ignored
      do_op(1, 17'h00004, 16'h5A5A, 2'b10, 1);
      step(0, 0, '0, '0, '0);
      chk(busy === 1'b0 && mem_we_n === 1'b1, "R2", "idle after ignored requests",
          {busy, mem_we_n}, 32'h1);
      // write after write: no turnaround
      do_op(1, 17'h00005, 16'hC3C3, 2'b11, 0);
      step(0, 0, '0, '0, '0);
      do_op(1, 17'h00006, 16'h0F0F, 2'b11, 0);
      step(0, 0, '0, '0, '0);
      // R2: requests during a read are ignored; back-to-back reads
      do_op(0, 17'h00005, '0, 2'b11, 1);
      do_op(0, 17'h00006, '0, 2'b01, 0);
      do_op(0, 17'h00004, '0, 2'b11, 0);
      do_op(1, 17'h00004, 16'h7777, 2'b00, 0);
      step(0, 0, '0, '0, '0);
      do_op(0, 17'h00004, '0, 2'b11, 0);
      repeat (3) step(0, 0, '0, '0, '0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule